// File: doc/BRIEF.md
# Two-Wire Bus Target with Access Status Flags

This block is the target (slave) side of a two-wire serial bus of the I2C kind. It watches the clock and data lines, finds start, repeated start and stop conditions, and compares each 7-bit address against an address given on a port. A match is acknowledged and opens an access. A mismatch is refused, and the rest of that transfer is ignored. Both bus lines are brought into the system clock domain before any edge is detected. The data line is driven open-drain: the block either pulls it low or lets it go.

Inside the chip, the block is used through two one-byte holding registers and five status flags. When the bus controller writes, each byte it sends lands in the receive holding register and raises a receive-ready flag. Reading that byte clears the flag. When the bus controller reads, the byte in the transmit holding register is moved into the shift register and sent out. A transmit-ready flag tells software when that byte has been consumed. Separate flags report:
- whether an access is open,
- the direction of the open access,
- that an access has just ended.

Top module: `i2c_target_flags`

## Requirements
- R1: After reset the access, direction, end-of-access and receive-ready flags are 0, transmit-ready is 1, and the data line is released.
- R2: An address byte is seven address bits, most significant first, followed by a direction bit (1 = the controller reads). When the address equals `own_addr`, the target pulls the data line low during the ninth clock, sets the access flag, and copies the direction bit into the direction flag.
- R3: When the address differs, the target leaves the data line released during the ninth clock and does not set the access flag. The following bytes of that transfer are neither acknowledged nor stored, and receive-ready stays 0.
- R4: During a write access, each received byte (most significant bit first) is copied into the receive holding register on the falling clock edge after its eighth bit. Receive-ready is set, and the target acknowledges the byte.
- R5: A one-cycle `rx_rd` pulse clears receive-ready.
- R6: In a read access, the transmit holding register is copied into the shift register at the falling clock edge that ends the address acknowledge, and again after each data byte the controller acknowledges. Transmit-ready clears at that moment, and the byte is sent most significant bit first.
- R7: Transmit-ready is set again on the rising edge of the ninth clock of a sent byte, whether the controller answers with ACK or NACK.
- R8: After a NACK from the controller on a sent byte, the target keeps the data line released until the next start or stop.
- R9: A stop clears the access flag. The end-of-access flag is set whenever the access flag falls, and is cleared when a new matching address sets the access flag.
- R10: A repeated start followed by the own address keeps the access open and updates the direction flag. A repeated start followed by another address clears the access flag.
- R11: Start and stop are recognised only when the data line changes while the clock line is high. Data-line changes while the clock is low do not disturb a transfer, and the target begins pulling the data line low only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_drive_low | output | 1 | 1 = pull the data line low, 0 = release it |
| own_addr | input | 7 | Address this target answers to |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Byte written to the transmit holding register |
| rx_rd | input | 1 | Read strobe; clears receive-ready |
| rx_data | output | 8 | Receive holding register |
| slv_acc | output | 1 | An access to this target is open |
| slv_dir | output | 1 | Direction of the open access (1 = controller reads) |
| acc_end | output | 1 | The last access has ended |
| tx_ready | output | 1 | Transmit holding register may take a new byte |
| rx_ready | output | 1 | Receive holding register holds an unread byte |

## Verification
A bus-line change reaches the synchronized level after two clocks and is turned into an event one clock later. The data-line drive therefore changes on the third clock after an edge, and the flags change on the fourth. The bench runs the bus clock with a half period of 20 system clocks, so every result is due long before the next edge. Acknowledge bits and transmitted data are sampled in the middle of the clock-high phase, and flags are sampled at least five clocks after the edge that causes them. Received bytes are checked as soon as receive-ready is seen, and the clearing by `rx_rd` is checked two clocks after the strobe.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = DATA_W - 1;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_RX,
        PH_RACK,
        PH_TX,
        PH_TACK,
        PH_WAIT
    } phase_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda_lvl;
    } bus_ev_t;

    function automatic logic addr_match(input logic [DATA_W-1:0] abyte,
                                        input logic [ADDR_W-1:0] own);
        return abyte[DATA_W-1:1] == own;
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_pin,
    input  logic    sda_pin,
    output bus_ev_t ev,
    output logic    scl_lvl
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins;
    logic [LINES-1:0] lvl;
    logic [LINES-1:0] prev;

    assign pins = {sda_pin, scl_pin};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], pins[g]};
        end
        assign lvl[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= lvl;
    end

    always_comb begin
        ev.scl_rise = lvl[0] & ~prev[0];
        ev.scl_fall = ~lvl[0] & prev[0];
        ev.start    = lvl[0] & prev[0] & prev[1] & ~lvl[1];
        ev.stop     = lvl[0] & prev[0] & ~prev[1] & lvl[1];
        ev.sda_lvl  = lvl[1];
    end

    assign scl_lvl = lvl[0];

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [DATA_W-1:0] thr,
    output logic              sda_oe,
    output logic              hit_p,
    output logic              hit_rw,
    output logic              miss_p,
    output logic              stop_p,
    output logic              rx_p,
    output logic [DATA_W-1:0] rx_byte,
    output logic              load_p,
    output logic              acked_p
);
    phase_e            phase;
    logic [DATA_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              full;
    logic              mack;
    logic              is_read;

    assign rx_byte = shreg;
    assign hit_rw  = is_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            shreg   <= '0;
            cnt     <= '0;
            full    <= 1'b0;
            mack    <= 1'b0;
            is_read <= 1'b0;
            sda_oe  <= 1'b0;
            hit_p   <= 1'b0;
            miss_p  <= 1'b0;
            stop_p  <= 1'b0;
            rx_p    <= 1'b0;
            load_p  <= 1'b0;
            acked_p <= 1'b0;
        end else begin
            hit_p   <= 1'b0;
            miss_p  <= 1'b0;
            stop_p  <= 1'b0;
            rx_p    <= 1'b0;
            load_p  <= 1'b0;
            acked_p <= 1'b0;
            if (ev.stop) begin
                phase  <= PH_IDLE;
                sda_oe <= 1'b0;
                full   <= 1'b0;
                stop_p <= 1'b1;
            end else if (ev.start) begin
                phase  <= PH_ADDR;
                sda_oe <= 1'b0;
                cnt    <= '0;
                full   <= 1'b0;
            end else begin
                unique case (phase)
                    PH_ADDR, PH_RX: begin
                        if (ev.scl_rise && !full) begin
                            shreg <= {shreg[DATA_W-2:0], ev.sda_lvl};
                            cnt   <= cnt + 1'b1;
                            if (cnt == CNT_W'(DATA_W - 1)) full <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (phase == PH_RX) begin
                                rx_p   <= 1'b1;
                                sda_oe <= 1'b1;
                                phase  <= PH_RACK;
                            end else if (addr_match(shreg, own_addr)) begin
                                sda_oe  <= 1'b1;
                                hit_p   <= 1'b1;
                                is_read <= shreg[0];
                                phase   <= PH_AACK;
                            end else begin
                                miss_p <= 1'b1;
                                phase  <= PH_WAIT;
                            end
                        end
                    end
                    PH_AACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                shreg  <= thr;
                                load_p <= 1'b1;
                                sda_oe <= ~thr[DATA_W-1];
                                phase  <= PH_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                phase  <= PH_RX;
                            end
                        end
                    end
                    PH_RACK: begin
                        if (ev.scl_fall) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_RX;
                        end
                    end
                    PH_TX: begin
                        if (ev.scl_fall) begin
                            if (cnt == CNT_W'(DATA_W - 1)) begin
                                sda_oe <= 1'b0;
                                cnt    <= '0;
                                full   <= 1'b0;
                                phase  <= PH_TACK;
                            end else begin
                                sda_oe <= ~shreg[DATA_W-2];
                                shreg  <= {shreg[DATA_W-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    PH_TACK: begin
                        if (ev.scl_rise && !full) begin
                            mack    <= ~ev.sda_lvl;
                            acked_p <= 1'b1;
                            full    <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            if (mack) begin
                                shreg  <= thr;
                                load_p <= 1'b1;
                                sda_oe <= ~thr[DATA_W-1];
                                phase  <= PH_TX;
                            end else begin
                                phase <= PH_WAIT;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_p,
    input  logic              hit_rw,
    input  logic              miss_p,
    input  logic              stop_p,
    input  logic              rx_p,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              load_p,
    input  logic              acked_p,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] thr,
    output logic [DATA_W-1:0] rhr,
    output logic              acc,
    output logic              dir,
    output logic              eoa,
    output logic              txrdy,
    output logic              rxrdy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            thr   <= '0;
            rhr   <= '0;
            acc   <= 1'b0;
            dir   <= 1'b0;
            eoa   <= 1'b0;
            txrdy <= 1'b1;
            rxrdy <= 1'b0;
        end else begin
            if (tx_wr) thr <= tx_data;

            if (rx_p) begin
                rhr   <= rx_byte;
                rxrdy <= 1'b1;
            end else if (rx_rd) begin
                rxrdy <= 1'b0;
            end

            if (load_p)       txrdy <= 1'b0;
            else if (acked_p) txrdy <= 1'b1;

            if (hit_p) begin
                acc <= 1'b1;
                dir <= hit_rw;
                eoa <= 1'b0;
            end else if (miss_p || stop_p) begin
                acc <= 1'b0;
                if (acc) eoa <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_target_flags.sv
module i2c_target_flags
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              slv_acc,
    output logic              slv_dir,
    output logic              acc_end,
    output logic              tx_ready,
    output logic              rx_ready
);
    bus_ev_t           bus_ev;
    logic              scl_lvl;
    logic [DATA_W-1:0] thr;
    logic [DATA_W-1:0] rx_byte;
    logic              hit_p, hit_rw, miss_p, stop_p, rx_p, load_p, acked_p;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_pin (scl_i),
        .sda_pin (sda_i),
        .ev      (bus_ev),
        .scl_lvl (scl_lvl)
    );

    i2c_tgt_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .own_addr (own_addr),
        .thr      (thr),
        .sda_oe   (sda_drive_low),
        .hit_p    (hit_p),
        .hit_rw   (hit_rw),
        .miss_p   (miss_p),
        .stop_p   (stop_p),
        .rx_p     (rx_p),
        .rx_byte  (rx_byte),
        .load_p   (load_p),
        .acked_p  (acked_p)
    );

    i2c_tgt_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .hit_p   (hit_p),
        .hit_rw  (hit_rw),
        .miss_p  (miss_p),
        .stop_p  (stop_p),
        .rx_p    (rx_p),
        .rx_byte (rx_byte),
        .load_p  (load_p),
        .acked_p (acked_p),
        .tx_wr   (tx_wr),
        .tx_data (tx_data),
        .rx_rd   (rx_rd),
        .thr     (thr),
        .rhr     (rx_data),
        .acc     (slv_acc),
        .dir     (slv_dir),
        .eoa     (acc_end),
        .txrdy   (tx_ready),
        .rxrdy   (rx_ready)
    );

endmodule

// File: rtl/i2c_target_flags_chk.sv
module i2c_target_flags_chk (
    input logic clk,
    input logic rst,
    input logic scl_lvl,
    input logic sda_oe,
    input logic acc,
    input logic dir,
    input logic eoa,
    input logic txrdy,
    input logic rxrdy
);
    // R2
    addr_ack_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(acc) |-> sda_oe);

    // R9
    end_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(acc) |-> eoa);

    // R9
    end_cleared_on_open_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(acc) |-> !eoa);

    // R4
    rx_only_in_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rxrdy) |-> (acc && !dir));

    // R6
    tx_load_only_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(txrdy) |-> (acc && dir));

    // R11
    drive_while_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && !$past(sda_oe)) |-> !$past(scl_lvl));

endmodule

bind i2c_target_flags i2c_target_flags_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .scl_lvl (scl_lvl),
    .sda_oe  (sda_drive_low),
    .acc     (slv_acc),
    .dir     (slv_dir),
    .eoa     (acc_end),
    .txrdy   (tx_ready),
    .rxrdy   (rx_ready)
);

// File: tb/i2c_target_flags_bench.sv
module i2c_target_flags_bench;
    localparam int HP      = 20;
    localparam int WDOG    = 150000;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_drive_low;
    logic [6:0] own_addr = OWN;
    logic       tx_wr = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_rd = 1'b0;
    logic [7:0] rx_data;
    logic       slv_acc, slv_dir, acc_end, tx_ready, rx_ready;
    logic       sda_line;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] rx_exp_q[$];

    assign sda_line = sda_m & ~sda_drive_low;

    always #5 clk = ~clk;

    i2c_target_flags u_i2c_target_flags (
        .clk           (clk),
        .rst           (rst),
        .scl_i         (scl_m),
        .sda_i         (sda_line),
        .sda_drive_low (sda_drive_low),
        .own_addr      (own_addr),
        .tx_wr         (tx_wr),
        .tx_data       (tx_data),
        .rx_rd         (rx_rd),
        .rx_data       (rx_data),
        .slv_acc       (slv_acc),
        .slv_dir       (slv_dir),
        .acc_end       (acc_end),
        .tx_ready      (tx_ready),
        .rx_ready      (rx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(HP);
        scl_m = 1'b1; tick(HP);
        scl_m = 1'b0;
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP/2);
        ack = ~sda_line;
        tick(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b, output logic rdy_probe);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(HP);
            scl_m = 1'b1; tick(HP/2);
            b[i] = sda_line;
            tick(HP/2);
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; tick(HP);
        scl_m = 1'b1; tick(HP/2);
        rdy_probe = tx_ready;
        tick(HP/2);
        scl_m = 1'b0;
    endtask

    task automatic write_thr(input logic [7:0] b);
        @(posedge clk); #2;
        tx_data = b; tx_wr = 1'b1;
        @(posedge clk); #2;
        tx_wr = 1'b0;
    endtask

    task automatic push_write(input logic [7:0] b, input string req);
        logic ack;
        rx_exp_q.push_back(b);
        write_byte(b, ack);
        chk(req, ack, 1'b1);
    endtask

    // Monitor: pops the expected byte whenever the receive holding register fills.
    initial begin
        forever begin
            @(posedge clk); #3;
            if (rx_ready && !rst) begin
                if (rx_exp_q.size() == 0) begin
                    n_chk++;
                    n_fail++;
                    $display("FAIL R3 unexpected byte: actual %0h expected none", rx_data);
                end else begin
                    chk("R4 received byte", rx_data, rx_exp_q.pop_front());
                end
                rx_rd = 1'b1;
                @(posedge clk); #3;
                rx_rd = 1'b0;
                @(posedge clk); #3;
                chk("R5 ready cleared by read", rx_ready, 1'b0);
            end
        end
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        logic       probe;

        tick(5);
        rst = 1'b0;
        tick(3);
        // R1 reset state
        chk("R1 access", slv_acc, 1'b0);
        chk("R1 direction", slv_dir, 1'b0);
        chk("R1 end", acc_end, 1'b0);
        chk("R1 tx ready", tx_ready, 1'b1);
        chk("R1 rx ready", rx_ready, 1'b0);
        chk("R1 drive", sda_drive_low, 1'b0);

        // R2 / R4: write access with two data bytes
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        chk("R2 address ack", ack, 1'b1);
        tick(5);
        chk("R2 access set", slv_acc, 1'b1);
        chk("R2 direction write", slv_dir, 1'b0);
        push_write(8'h5C, "R4 data ack");
        push_write(8'hA3, "R4 data ack");
        wait (rx_exp_q.size() == 0);
        tick(4);
        bus_stop();
        tick(5);
        chk("R9 stop clears access", slv_acc, 1'b0);
        chk("R9 end flag set", acc_end, 1'b1);

        // R3: address mismatch, following byte ignored
        bus_start();
        write_byte({7'h11, 1'b0}, ack);
        chk("R3 address nack", ack, 1'b0);
        tick(5);
        chk("R3 access stays low", slv_acc, 1'b0);
        write_byte(8'h00, ack);
        chk("R3 data not acked", ack, 1'b0);
        tick(5);
        chk("R3 rx ready stays low", rx_ready, 1'b0);
        bus_stop();

        // R6 / R7 / R8: read access
        write_thr(8'h96);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R2 read address ack", ack, 1'b1);
        tick(5);
        chk("R2 direction read", slv_dir, 1'b1);
        chk("R9 end cleared on open", acc_end, 1'b0);
        chk("R6 tx ready cleared on load", tx_ready, 1'b0);
        write_thr(8'h3B);
        read_byte(1'b1, rb, probe);
        chk("R6 first byte", rb, 8'h96);
        chk("R7 ready on acked byte", probe, 1'b1);
        tick(5);
        chk("R6 reload clears ready", tx_ready, 1'b0);
        read_byte(1'b0, rb, probe);
        chk("R6 second byte", rb, 8'h3B);
        chk("R7 ready on refused byte", probe, 1'b1);
        tick(5);
        chk("R8 no reload after nack", tx_ready, 1'b1);
        read_byte(1'b0, rb, probe);
        chk("R8 line released", rb, 8'hFF);
        bus_stop();
        tick(5);
        chk("R9 access closed", slv_acc, 1'b0);
        chk("R9 end after read", acc_end, 1'b1);

        // R10: repeated starts
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        tick(5);
        chk("R10 write open", {slv_acc, slv_dir}, 2'b10);
        write_thr(8'h4E);
        bus_start();
        write_byte({OWN, 1'b1}, ack);
        chk("R10 restart ack", ack, 1'b1);
        tick(5);
        chk("R10 restart keeps access, read dir", {slv_acc, slv_dir, acc_end}, 3'b110);
        read_byte(1'b0, rb, probe);
        chk("R10 byte after restart", rb, 8'h4E);
        bus_start();
        write_byte({7'h33, 1'b0}, ack);
        chk("R10 other address nack", ack, 1'b0);
        tick(5);
        chk("R10 other address closes", {slv_acc, acc_end}, 2'b01);
        bus_stop();

        // R11: data toggles while clock low do not disturb a transfer
        bus_start();
        write_byte({OWN, 1'b0}, ack);
        tick(5);
        sda_m = 1'b0; tick(HP);
        sda_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        chk("R11 access kept", slv_acc, 1'b1);
        push_write(8'h81, "R11 byte after toggles");
        wait (rx_exp_q.size() == 0);
        tick(4);
        bus_stop();
        tick(5);
        chk("R11 queue drained", rx_exp_q.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule